// File: doc/BRIEF.md
# Segmented Real-Mode Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical byte address. The segment value is shifted left by four bit positions and the offset is added to it. It holds four segment registers: code, data, extra and stack. For each access it picks one of them from the kind of access being made. An override input can redirect ordinary data and stack-based operand accesses to any of the four registers. Instruction fetch and string-destination accesses always use their fixed segment.

The block also keeps the source and destination index registers used by string operations. One step request moves both indexes by the element size, which is 1, 2 or 4 bytes. A direction input chooses whether they count up or down. Indexes wrap within 16 bits, and the physical address wraps within 1 MB.

The address path is combinational from the registered segment values. Segment writes and index updates take effect on the clock edge that samples them.

Top module: `rm_addr_gen`

## Requirements
- R1: A synchronous active-low reset clears all four segment registers and both index registers to zero.
- R2: When `seg_wr_en` is high at a clock edge, the register chosen by `seg_wr_sel` (0 extra, 1 code, 2 stack, 3 data) takes `seg_wr_data`. The other registers and every register on cycles without the strobe keep their values.
- R3: `phys_addr` equals (segment × 16 + offset) modulo 2^20, where the segment is the register reported on `seg_used`. For example, FFFFh:4000h gives 03FF0h.
- R4: An instruction fetch (`acc_kind` = 0) always uses the code segment, whatever the override inputs hold. For example, 1400h:1200h gives 15200h.
- R5: A stack-based access (`acc_kind` = 1, stack or base pointer) uses the stack segment when no override is given. For example, 2000h:3000h gives 23000h.
- R6: A general data access (`acc_kind` = 2) uses the data segment when no override is given.
- R7: A string-destination access (`acc_kind` = 3) always uses the extra segment, whatever the override inputs hold.
- R8: When `ovr_en` is high, data and stack-based accesses use the segment chosen by `ovr_sel`, with the same encoding as in R2.
- R9: On a step with `dir_down` = 0, both indexes increase by the step size. With `dir_down` = 1 both decrease. Results wrap modulo 2^16.
- R10: The step size is 1 for `elem_size` 0, 2 for `elem_size` 1, and 4 for `elem_size` 2 or 3.
- R11: `idx_load` loads `src_load_val` and `dst_load_val` and takes priority over a step in the same cycle. With neither request, the indexes hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment register to write (0 extra, 1 code, 2 stack, 3 data) |
| seg_wr_data | input | 16 | Value to write |
| acc_kind | input | 2 | Access kind (0 fetch, 1 stack-based, 2 data, 3 string destination) |
| ovr_en | input | 1 | Segment override enable |
| ovr_sel | input | 2 | Override segment |
| offset | input | 16 | Offset within the segment |
| phys_addr | output | 20 | Physical address |
| seg_used | output | 2 | Segment chosen for this access |
| idx_load | input | 1 | Load both index registers |
| src_load_val | input | 16 | Source index load value |
| dst_load_val | input | 16 | Destination index load value |
| str_step | input | 1 | Advance both indexes one element |
| dir_down | input | 1 | 1 = decrement, 0 = increment |
| elem_size | input | 2 | Element size code (0 byte, 1 word, 2 or 3 double word) |
| src_idx | output | 16 | Source index |
| dst_idx | output | 16 | Destination index |

## Verification
A wrong segment register value appears on `phys_addr` at once, in the same cycle as any access that selects that register. The bench therefore reads back every register through each access kind, with and without override, after each write.

A faulty selection rule shows on `seg_used` and in the upper address bits without delay. A faulty index update shows one cycle after the step that caused it. The indexes are checked after every step near both ends of the 16-bit range, so errors in the wrap or the step size show within a single step.

// File: rtl/rmag_pkg.sv
// Package: shared encodings for the segmented address generator.
// Assumes the segment id encoding is also the override and write-select encoding.
package rmag_pkg;
    typedef enum logic [1:0] {
        SEG_EXTRA = 2'd0,
        SEG_CODE  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_DATA  = 2'd3
    } seg_id_t;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_STACK = 2'd1,
        ACC_DATA  = 2'd2,
        ACC_SDEST = 2'd3
    } acc_kind_t;
endpackage

// File: rtl/rmag_seg_regs.sv
// Module: bank of segment registers with a single write port.
// Assumes a synchronous active-low reset that clears every register to zero.
module rmag_seg_regs #(
    parameter int NUM_SEG = 4,
    parameter int SEG_W   = 16,
    localparam int SEL_W  = $clog2(NUM_SEG)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [SEL_W-1:0]               wr_sel,
    input  logic [SEG_W-1:0]               wr_data,
    output logic [NUM_SEG-1:0][SEG_W-1:0]  seg_q
);
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        // Load this register when the write strobe names it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                seg_q[g] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(g)))
                seg_q[g] <= wr_data;
        end

        p_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == SEL_W'(g)) |=> seg_q[g] == $past(wr_data));

        p_other_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_sel == SEL_W'(g)) |=> $stable(seg_q[g]));
    end
endmodule

// File: rtl/rmag_seg_select.sv
// Module: picks the segment for an access from its kind and the override.
// Assumes the override only applies to data and stack-based operand accesses.
module rmag_seg_select
    import rmag_pkg::*;
(
    input  acc_kind_t kind,
    input  logic      ovr_en,
    input  seg_id_t   ovr_sel,
    output seg_id_t   sel
);
    // Apply the default rule per access kind, then the override where allowed.
    always_comb begin
        unique case (kind)
            ACC_FETCH: sel = SEG_CODE;
            ACC_SDEST: sel = SEG_EXTRA;
            ACC_STACK: sel = ovr_en ? ovr_sel : SEG_STACK;
            default:   sel = ovr_en ? ovr_sel : SEG_DATA;
        endcase
    end
endmodule

// File: rtl/rmag_addr_adder.sv
// Module: forms a physical address as segment shifted left plus offset.
// Assumes ADDR_W = SEG_W + SHIFT and OFF_W <= ADDR_W; the carry out is dropped.
module rmag_addr_adder #(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] phys
);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] off_ext;

    // Widen both operands and add them, wrapping at the address width.
    always_comb begin
        base    = {seg, {SHIFT{1'b0}}};
        off_ext = {{(ADDR_W-OFF_W){1'b0}}, off};
        phys    = base + off_ext;
    end

    // The low nibble comes from the offset alone, because the shifted base is zero there.
    always_comb begin
        p_low_nibble_r3: assert (phys[SHIFT-1:0] == off[SHIFT-1:0]);
    end
endmodule

// File: rtl/rmag_idx_step.sv
// Module: one string index register that steps up or down by the element size.
// Assumes a load has priority over a step, and the value wraps within IDX_W bits.
module rmag_idx_step #(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             step,
    input  logic             dir_down,
    input  logic [1:0]       elem_size,
    output logic [IDX_W-1:0] idx_q
);
    logic [IDX_W-1:0] step_amt;

    // Decode the element size code into a byte count.
    always_comb begin
        unique case (elem_size)
            2'd0:    step_amt = IDX_W'(1);
            2'd1:    step_amt = IDX_W'(2);
            default: step_amt = IDX_W'(4);
        endcase
    end

    // Update the index: load first, then step, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (load)
            idx_q <= load_val;
        else if (step)
            idx_q <= dir_down ? (idx_q - step_amt) : (idx_q + step_amt);
    end

    p_step_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !dir_down && elem_size == 2'd0) |=> idx_q == $past(idx_q) + IDX_W'(1));

    p_step_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && dir_down && elem_size == 2'd1) |=> idx_q == $past(idx_q) - IDX_W'(2));

    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> idx_q == $past(load_val));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(idx_q));
endmodule

// File: rtl/rm_addr_gen.sv
// Module: real-mode address generator top level. It holds the segment registers,
// picks the segment for each access, forms the 20-bit address and steps the
// string indexes. Assumes the offset and access kind are stable while phys_addr is used.
module rm_addr_gen
    import rmag_pkg::*;
#(
    parameter int SEG_W   = 16,
    parameter int OFF_W   = 16,
    parameter int SHIFT   = 4,
    parameter int IDX_W   = 16,
    parameter int NUM_SEG = 4,
    localparam int ADDR_W = SEG_W + SHIFT,
    localparam int SEL_W  = $clog2(NUM_SEG),
    localparam int NUM_IDX = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_wr_en,
    input  logic [SEL_W-1:0]  seg_wr_sel,
    input  logic [SEG_W-1:0]  seg_wr_data,
    input  logic [1:0]        acc_kind,
    input  logic              ovr_en,
    input  logic [SEL_W-1:0]  ovr_sel,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] phys_addr,
    output logic [SEL_W-1:0]  seg_used,
    input  logic              idx_load,
    input  logic [IDX_W-1:0]  src_load_val,
    input  logic [IDX_W-1:0]  dst_load_val,
    input  logic              str_step,
    input  logic              dir_down,
    input  logic [1:0]        elem_size,
    output logic [IDX_W-1:0]  src_idx,
    output logic [IDX_W-1:0]  dst_idx
);
    logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;
    seg_id_t                       sel;
    logic [SEG_W-1:0]              seg_val;
    logic [NUM_IDX-1:0][IDX_W-1:0] idx_load_vals;
    logic [NUM_IDX-1:0][IDX_W-1:0] idx_vals;

    rmag_seg_regs #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .seg_q   (seg_q)
    );

    rmag_seg_select u_sel (
        .kind    (acc_kind_t'(acc_kind)),
        .ovr_en  (ovr_en),
        .ovr_sel (seg_id_t'(ovr_sel)),
        .sel     (sel)
    );

    // Route the chosen segment register to the adder and report its id.
    always_comb begin
        seg_val  = seg_q[sel];
        seg_used = SEL_W'(sel);
    end

    rmag_addr_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_add (
        .seg  (seg_val),
        .off  (offset),
        .phys (phys_addr)
    );

    // Gather the load values so one generate loop builds both index registers.
    always_comb begin
        idx_load_vals[0] = src_load_val;
        idx_load_vals[1] = dst_load_val;
    end

    for (genvar i = 0; i < NUM_IDX; i++) begin : g_idx
        rmag_idx_step #(.IDX_W(IDX_W)) u_step (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (idx_load),
            .load_val  (idx_load_vals[i]),
            .step      (str_step),
            .dir_down  (dir_down),
            .elem_size (elem_size),
            .idx_q     (idx_vals[i])
        );
    end

    // Drive the index outputs from the two stepper instances.
    always_comb begin
        src_idx = idx_vals[0];
        dst_idx = idx_vals[1];
    end

    p_fetch_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'd0) |-> (seg_used == SEL_W'(SEG_CODE)));

    p_sdest_extra_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'd3) |-> (seg_used == SEL_W'(SEG_EXTRA)));

    p_stack_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'd1 && !ovr_en) |-> (seg_used == SEL_W'(SEG_STACK)));

    p_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind[1] != acc_kind[0] && ovr_en) |-> (seg_used == ovr_sel));
endmodule

// File: tb/rm_addr_gen_bench.sv
module rm_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        seg_wr_en;
    logic [1:0]  seg_wr_sel;
    logic [15:0] seg_wr_data;
    logic [1:0]  acc_kind;
    logic        ovr_en;
    logic [1:0]  ovr_sel;
    logic [15:0] offset;
    logic [19:0] phys_addr;
    logic [1:0]  seg_used;
    logic        idx_load;
    logic [15:0] src_load_val;
    logic [15:0] dst_load_val;
    logic        str_step;
    logic        dir_down;
    logic [1:0]  elem_size;
    logic [15:0] src_idx;
    logic [15:0] dst_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] shadow [4];

    always #4 clk = ~clk;

    rm_addr_gen u_rm_addr_gen (
        .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel),
        .seg_wr_data(seg_wr_data), .acc_kind(acc_kind), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
        .offset(offset), .phys_addr(phys_addr), .seg_used(seg_used), .idx_load(idx_load),
        .src_load_val(src_load_val), .dst_load_val(dst_load_val), .str_step(str_step),
        .dir_down(dir_down), .elem_size(elem_size), .src_idx(src_idx), .dst_idx(dst_idx)
    );

    task automatic chk(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [1:0] exp_sel(input logic [1:0] k, input logic oe, input logic [1:0] os);
        case (k)
            2'd0: return 2'd1;
            2'd3: return 2'd0;
            2'd1: return oe ? os : 2'd2;
            default: return oe ? os : 2'd3;
        endcase
    endfunction

    function automatic logic [19:0] exp_addr(input logic [15:0] s, input logic [15:0] o);
        logic [20:0] sum;
        sum = {5'd0, s} * 21'd16 + {5'd0, o};
        return sum[19:0];
    endfunction

    function automatic logic [15:0] step_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 16'd1 : (sz == 2'd1) ? 16'd2 : 16'd4;
    endfunction

    task automatic write_seg(input logic [1:0] sel, input logic [15:0] val);
        seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = val;
        tick();
        seg_wr_en = 1'b0;
        shadow[sel] = val;
    endtask

    task automatic access(input logic [1:0] k, input logic oe, input logic [1:0] os,
                          input logic [15:0] off, input string tag);
        logic [1:0] es;
        acc_kind = k; ovr_en = oe; ovr_sel = os; offset = off;
        #1;
        es = exp_sel(k, oe, os);
        chk(seg_used == es, {tag, " segment"}, {18'd0, seg_used}, {18'd0, es});
        chk(phys_addr == exp_addr(shadow[es], off), {tag, " R3 address"}, phys_addr,
            exp_addr(shadow[es], off));
    endtask

    task automatic sweep();
        logic [15:0] offs [4];
        offs[0] = 16'h0000; offs[1] = 16'h1200; offs[2] = 16'hFFFF; offs[3] = 16'h8001;
        for (int k = 0; k < 4; k++)
            for (int oe = 0; oe < 2; oe++)
                for (int os = 0; os < 4; os++)
                    for (int j = 0; j < 4; j++)
                        access(2'(k), 1'(oe), 2'(os), offs[j],
                               k == 0 ? "R4 fetch" : k == 3 ? "R7 sdest" :
                               oe != 0 ? "R8 override" : k == 1 ? "R5 stack" : "R6 data");
    endtask

    task automatic check_reset_state(input string when);
        for (int k = 0; k < 4; k++) begin
            acc_kind = 2'(k); ovr_en = 1'b0; offset = 16'h0000;
            #1;
            chk(phys_addr == 20'h0, {"R1 segment zero ", when}, phys_addr, 20'h0);
        end
        chk(src_idx == 16'h0, {"R1 src zero ", when}, {4'd0, src_idx}, 20'h0);
        chk(dst_idx == 16'h0, {"R1 dst zero ", when}, {4'd0, dst_idx}, 20'h0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] es, ed, stp;
        rst_n = 1'b0; seg_wr_en = 1'b0; seg_wr_sel = 2'd0; seg_wr_data = 16'h0;
        acc_kind = 2'd0; ovr_en = 1'b0; ovr_sel = 2'd0; offset = 16'h0;
        idx_load = 1'b0; src_load_val = 16'h0; dst_load_val = 16'h0;
        str_step = 1'b0; dir_down = 1'b0; elem_size = 2'd0;
        for (int i = 0; i < 4; i++) shadow[i] = 16'h0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        check_reset_state("after power-up");

        // R2: write each register in turn and read every register back.
        write_seg(2'd0, 16'h3000);
        sweep();
        write_seg(2'd1, 16'h1400);
        write_seg(2'd2, 16'h2000);
        write_seg(2'd3, 16'hFFFF);
        sweep();

        // Worked examples of R3 to R6.
        access(2'd0, 1'b1, 2'd3, 16'h1200, "R4 example");
        chk(phys_addr == 20'h15200, "R4 example value", phys_addr, 20'h15200);
        access(2'd1, 1'b0, 2'd0, 16'h3000, "R5 example");
        chk(phys_addr == 20'h23000, "R5 example value", phys_addr, 20'h23000);
        access(2'd2, 1'b0, 2'd0, 16'h4000, "R6 wrap");
        chk(phys_addr == 20'h03FF0, "R3 wrap value", phys_addr, 20'h03FF0);

        // R2: a strobe-free cycle with a data value present changes nothing.
        seg_wr_sel = 2'd1; seg_wr_data = 16'hABCD;
        tick();
        access(2'd0, 1'b0, 2'd0, 16'h0000, "R2 no strobe");
        write_seg(2'd1, 16'hF123);
        sweep();

        // R9 and R10: step in both directions at every size across both wrap points.
        for (int d = 0; d < 2; d++)
            for (int sz = 0; sz < 4; sz++) begin
                idx_load = 1'b1; src_load_val = 16'hFFFE; dst_load_val = 16'h0001;
                tick();
                idx_load = 1'b0;
                es = 16'hFFFE; ed = 16'h0001; stp = step_of(2'(sz));
                str_step = 1'b1; dir_down = 1'(d); elem_size = 2'(sz);
                for (int n = 0; n < 3; n++) begin
                    tick();
                    es = d ? es - stp : es + stp;
                    ed = d ? ed - stp : ed + stp;
                    chk(src_idx == es, "R9 R10 src step", {4'd0, src_idx}, {4'd0, es});
                    chk(dst_idx == ed, "R9 R10 dst step", {4'd0, dst_idx}, {4'd0, ed});
                end
                str_step = 1'b0;
            end

        // R11: a load in the same cycle as a step wins, then the indexes hold.
        idx_load = 1'b1; str_step = 1'b1; src_load_val = 16'h1234; dst_load_val = 16'h5678;
        tick();
        idx_load = 1'b0; str_step = 1'b0;
        chk(src_idx == 16'h1234, "R11 load priority src", {4'd0, src_idx}, 20'h01234);
        chk(dst_idx == 16'h5678, "R11 load priority dst", {4'd0, dst_idx}, 20'h05678);
        tick(); tick();
        chk(src_idx == 16'h1234, "R11 hold src", {4'd0, src_idx}, 20'h01234);
        chk(dst_idx == 16'h5678, "R11 hold dst", {4'd0, dst_idx}, 20'h05678);

        // R1: a reset in mid-run clears everything.
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) shadow[i] = 16'h0;
        check_reset_state("mid-run");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule